// File: doc/BRIEF.md
# Synthesizer Serial Programming Master

This block sits on the host side of a three-wire programming link to a frequency synthesizer. The three wires are a serial clock, a serial data line and an enable strobe. A caller presents a parallel frame of several bytes and a band-mode bit, then pulses a start input for one cycle. The block captures both and sends the frame one byte at a time. Each byte has its own enable window. The synthesizer captures data on the falling edge of the serial clock, so the block changes the data line only when the serial clock rises or when a new enable window opens.

Every bus timing is a whole number of system-clock cycles, set by parameters. Each default is derived from the system clock frequency and rounded up, so no minimum time is broken. Between two bytes the bus is released: enable is low and the clock is held low. This release is short after most bytes. After the fourth byte it is long, and its length depends on the band latched at start (a long wait for AM, a shorter one for FM). A busy output covers the whole transfer. A one-cycle done pulse marks the end of the transfer.

Top module: `synp_master`

## Requirements
- R1: After reset, and whenever no transfer is running, ser_clk_o, ser_en_o, busy_o and done_o are all low.
- R2: Byte k of a frame is frame_i[8k+7:8k]. Bytes go out for k = 0, 1, …, NBYTES-1 in that order, each byte MSB first. Each bit is the value of ser_data_o at a falling edge of ser_clk_o, with eight falling edges per enable window.
- R3: Each high phase and each low phase of ser_clk_o inside a byte lasts HALF_CYC system cycles.
- R4: ser_en_o rises only while ser_clk_o is low. For the first byte it rises LEAD_CYC+1 cycles after the cycle in which start_i is sampled high. In every byte, ser_clk_o first rises SETUP_CYC cycles after ser_en_o rises.
- R5: While ser_en_o is high, ser_data_o changes only in the cycle where ser_clk_o rises or where ser_en_o rises. It is therefore stable through every high phase, and through the whole low phase that follows each falling edge.
- R6: ser_clk_o is never high while ser_en_o is low. ser_en_o falls HALF_CYC cycles after the eighth falling edge of the byte, with ser_clk_o low.
- R7: Between byte k-1 and byte k, for every k other than 4, ser_en_o stays low for exactly GAP_CYC cycles.
- R8: Between the fourth and fifth byte, ser_en_o stays low for GAP_FM_CYC cycles when the latched mode is 0 (FM), and for GAP_AM_CYC cycles when it is 1 (AM).
- R9: am_mode_i is sampled only in the cycle a start is accepted. Changing it later has no effect on the running transfer.
- R10: A start_i pulse while busy_o is high is ignored, and so is any change of frame_i during that time. The running frame goes out unchanged.
- R11: busy_o is high from the cycle after an accepted start until done_o. done_o is high for exactly one cycle, END_CYC cycles after the last falling edge of ser_en_o, and busy_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a frame |
| am_mode_i | input | 1 | Band select sampled at start: 1 = AM, 0 = FM |
| frame_i | input | NBYTES*8 | Parallel frame, byte k in bits [8k+7:8k] |
| ser_clk_o | output | 1 | Serial clock to the synthesizer |
| ser_data_o | output | 1 | Serial data, MSB first |
| ser_en_o | output | 1 | Per-byte enable strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The embedded properties check the bus rules on every cycle. The clock may only be high inside an enable window, and the enable may only rise or fall with the clock low. Data stays stable across high phases and after falling edges. The done pulse lasts one cycle and never overlaps busy, and the latched band does not move while busy. Only the directed scenarios can show the rest: the exact phase widths, each gap length (including which band picks the long gap after the fourth byte), the setup from start to the first enable, the recovered byte order and bit order, and a frame left untouched by a stray start or a band change in mid-transfer.

// File: rtl/synp_pkg.sv
package synp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_ENA,
      ST_HIGH,
      ST_LOW,
      ST_GAP,
      ST_TAIL
   } synp_state_e;

   // convert a minimum time in ns into system cycles, rounding up
   function automatic int ns_to_cyc(input int sys_mhz, input int ns);
      longint prod;
      prod = longint'(ns) * longint'(sys_mhz);
      return int'((prod + 64'd999) / 64'd1000);
   endfunction

   function automatic int cmax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/synp_timer.sv
module synp_timer #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= len_i - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // R3
   len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (len_i != '0));

endmodule

// File: rtl/synp_bitsel.sv
module synp_bitsel #(
   parameter int NBYTES = 6
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic [NBYTES*8-1:0]   frame_i,
   input  logic                  step_bit_i,
   input  logic                  step_byte_i,
   output logic                  bit_o,
   output logic                  last_bit_o,
   output logic                  last_byte_o,
   output logic [$clog2(NBYTES)-1:0] byte_idx_o
);

   localparam int BW = $clog2(NBYTES);
   localparam int FW = NBYTES * 8;

   logic [FW-1:0] frame_q;
   logic [BW-1:0] byte_q;
   logic [2:0]    bit_q;
   logic [7:0]    byte_arr [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign byte_arr[g] = frame_q[8*g +: 8];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frame_q <= '0;
         byte_q  <= '0;
         bit_q   <= 3'd7;
      end else if (load_i) begin
         frame_q <= frame_i;
         byte_q  <= '0;
         bit_q   <= 3'd7;
      end else if (step_byte_i) begin
         byte_q  <= byte_q + 1'b1;
         bit_q   <= 3'd7;
      end else if (step_bit_i) begin
         bit_q   <= bit_q - 1'b1;
      end
   end

   assign bit_o       = byte_arr[byte_q][bit_q];
   assign last_bit_o  = (bit_q == 3'd0);
   assign last_byte_o = (byte_q == BW'(NBYTES - 1));
   assign byte_idx_o  = byte_q;

   // R2
   byte_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_q <= BW'(NBYTES - 1));

   // R2
   bit_step_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_bit_i |-> (bit_q != 3'd0));

   // R2
   byte_step_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_byte_i |-> (byte_q != BW'(NBYTES - 1)));

endmodule

// File: rtl/synp_master.sv
module synp_master
   import synp_pkg::*;
#(
   parameter int SYS_MHZ    = 200,
   parameter int NBYTES     = 6,
   parameter int HALF_CYC   = ns_to_cyc(SYS_MHZ, 1000),
   parameter int LEAD_CYC   = ns_to_cyc(SYS_MHZ, 200),
   parameter int SETUP_CYC  = ns_to_cyc(SYS_MHZ, 100),
   parameter int FALL_CYC   = ns_to_cyc(SYS_MHZ, 400),
   parameter int END_CYC    = ns_to_cyc(SYS_MHZ, 400),
   parameter int GAP_CYC    = ns_to_cyc(SYS_MHZ, 5000),
   parameter int GAP_FM_CYC = ns_to_cyc(SYS_MHZ, 180000),
   parameter int GAP_AM_CYC = ns_to_cyc(SYS_MHZ, 2000000)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                am_mode_i,
   input  logic [NBYTES*8-1:0] frame_i,
   output logic                ser_clk_o,
   output logic                ser_data_o,
   output logic                ser_en_o,
   output logic                busy_o,
   output logic                done_o
);

   localparam int SLOW_IDX = 3;
   localparam int BW       = $clog2(NBYTES);
   localparam int MAXC     = cmax(cmax(cmax(GAP_AM_CYC, GAP_FM_CYC), cmax(GAP_CYC, HALF_CYC)),
                                  cmax(cmax(LEAD_CYC, SETUP_CYC), END_CYC));
   localparam int TW       = $clog2(MAXC + 1);

   // elaboration-time parameter checks
   if (NBYTES < 4) begin : g_bad_nbytes
      $error("synp_master: NBYTES must be at least 4");
   end
   if (HALF_CYC < 1 || LEAD_CYC < 1 || SETUP_CYC < 1 || END_CYC < 1) begin : g_bad_phase
      $error("synp_master: every phase count must be at least 1");
   end
   if (HALF_CYC < FALL_CYC) begin : g_bad_fall
      $error("synp_master: HALF_CYC must cover the enable fall hold");
   end
   if (GAP_CYC < LEAD_CYC || GAP_FM_CYC < GAP_CYC || GAP_AM_CYC < GAP_CYC) begin : g_bad_gap
      $error("synp_master: gap counts inconsistent");
   end

   synp_state_e       state_q, state_d;
   logic              mode_q;
   logic              done_q;
   logic              tmr_zero;
   logic              tmr_load;
   logic [TW-1:0]     dur_d;
   logic [TW-1:0]     gap_len;
   logic              long_sel;
   logic              accept;
   logic              step_bit, step_byte;
   logic              bit_val, last_bit, last_byte;
   logic [BW-1:0]     byte_idx;

   assign accept = (state_q == ST_IDLE) && start_i;

   // long release after the fourth byte exists only if a fifth byte follows
   if (NBYTES > SLOW_IDX + 1) begin : g_long_gap
      assign long_sel = (byte_idx == BW'(SLOW_IDX));
   end else begin : g_no_long_gap
      assign long_sel = 1'b0;
   end

   assign gap_len = long_sel ? (mode_q ? TW'(GAP_AM_CYC) : TW'(GAP_FM_CYC))
                             : TW'(GAP_CYC);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)  state_d = ST_LEAD;
         ST_LEAD: if (tmr_zero) state_d = ST_ENA;
         ST_ENA:  if (tmr_zero) state_d = ST_HIGH;
         ST_HIGH: if (tmr_zero) state_d = ST_LOW;
         ST_LOW: begin
            if (tmr_zero) begin
               if (!last_bit)      state_d = ST_HIGH;
               else if (last_byte) state_d = ST_TAIL;
               else                state_d = ST_GAP;
            end
         end
         ST_GAP:  if (tmr_zero) state_d = ST_ENA;
         ST_TAIL: if (tmr_zero) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_LEAD:         dur_d = TW'(LEAD_CYC);
         ST_ENA:          dur_d = TW'(SETUP_CYC);
         ST_HIGH, ST_LOW: dur_d = TW'(HALF_CYC);
         ST_GAP:          dur_d = gap_len;
         ST_TAIL:         dur_d = TW'(END_CYC);
         default:         dur_d = TW'(1);
      endcase
   end

   assign tmr_load  = (state_d != state_q);
   assign step_bit  = (state_q == ST_LOW) && (state_d == ST_HIGH);
   assign step_byte = (state_q == ST_GAP) && (state_d == ST_ENA);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_TAIL) && (state_d == ST_IDLE);
         if (accept) mode_q <= am_mode_i;
      end
   end

   synp_timer #(
      .W (TW)
   ) i_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load),
      .len_i  (dur_d),
      .zero_o (tmr_zero)
   );

   synp_bitsel #(
      .NBYTES (NBYTES)
   ) i_bitsel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (accept),
      .frame_i     (frame_i),
      .step_bit_i  (step_bit),
      .step_byte_i (step_byte),
      .bit_o       (bit_val),
      .last_bit_o  (last_bit),
      .last_byte_o (last_byte),
      .byte_idx_o  (byte_idx)
   );

   assign ser_clk_o  = (state_q == ST_HIGH);
   assign ser_en_o   = (state_q == ST_ENA) || (state_q == ST_HIGH) || (state_q == ST_LOW);
   assign ser_data_o = bit_val;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;

   // R6
   clk_inside_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_clk_o |-> ser_en_o);

   // R4
   en_rise_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ser_en_o) |-> (!ser_clk_o && !$past(ser_clk_o)));

   // R6
   en_fall_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ser_en_o) |-> (!ser_clk_o && !$past(ser_clk_o)));

   // R5
   data_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

   // R5
   data_stable_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ser_clk_o && !$past(ser_clk_o) && ser_en_o && $past(ser_en_o)) |-> $stable(ser_data_o));

   // R11
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11
   done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R9
   mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> $stable(mode_q));

endmodule

// File: tb/test_synp_master.sv
`timescale 1ns/1ps
module test_synp_master;

   localparam int NB    = 5;
   localparam int FW    = NB * 8;
   localparam int HALF  = 6;
   localparam int LEAD  = 3;
   localparam int SETUP = 2;
   localparam int FALLC = 4;
   localparam int ENDC  = 5;
   localparam int GAP   = 10;
   localparam int GFM   = 40;
   localparam int GAM   = 90;
   localparam int LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          am = 1'b0;
   logic [FW-1:0] frame = '0;
   logic          ser_clk, ser_data, ser_en, busy, done;

   always #2.5 clk = ~clk;

   synp_master #(
      .SYS_MHZ    (200),
      .NBYTES     (NB),
      .HALF_CYC   (HALF),
      .LEAD_CYC   (LEAD),
      .SETUP_CYC  (SETUP),
      .FALL_CYC   (FALLC),
      .END_CYC    (ENDC),
      .GAP_CYC    (GAP),
      .GAP_FM_CYC (GFM),
      .GAP_AM_CYC (GAM)
   ) i_synp_master (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .am_mode_i  (am),
      .frame_i    (frame),
      .ser_clk_o  (ser_clk),
      .ser_data_o (ser_data),
      .ser_en_o   (ser_en),
      .busy_o     (busy),
      .done_o     (done)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // bus monitor state
   int   cyc = 0;
   int   t_start, t_rise, t_fall, t_drise, t_dfall, t_done;
   int   bits, nb, done_cnt;
   logic [7:0] cur;
   logic [7:0] caps [0:15];
   int   gaps [0:15];
   logic p_sc = 1'b0, p_sd = 1'b0, p_de = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (start && !busy) t_start = cyc;
         if (ser_clk && !p_sc) begin
            if (bits == 0) chk(cyc - t_drise == SETUP, "R4", cyc - t_drise, SETUP);
            else           chk(cyc - t_fall == HALF, "R3", cyc - t_fall, HALF);
            t_rise = cyc;
         end
         if (!ser_clk && p_sc) begin
            chk(cyc - t_rise == HALF, "R3", cyc - t_rise, HALF);
            cur  = {cur[6:0], ser_data};
            bits = bits + 1;
            t_fall = cyc;
            if (bits == 8 && nb < 16) begin
               caps[nb] = cur;
               nb = nb + 1;
            end
         end
         if (ser_data != p_sd)
            chk((ser_clk && !p_sc) || (ser_en && !p_de) || !ser_en, "R5", 1, 0);
         if (ser_clk && !ser_en) chk(1'b0, "R6", 1, 0);
         if (ser_en && !p_de) begin
            chk(!ser_clk, "R4", ser_clk, 0);
            if (nb > 0 && nb < 16) gaps[nb] = cyc - t_dfall;
            else if (nb == 0) chk(cyc - t_start == LEAD + 1, "R4", cyc - t_start, LEAD + 1);
            t_drise = cyc;
         end
         if (!ser_en && p_de) begin
            chk(bits == 8, "R2", bits, 8);
            chk(cyc - t_fall == HALF, "R6", cyc - t_fall, HALF);
            bits = 0;
            t_dfall = cyc;
         end
         if (done) begin
            if (done_cnt == 0) t_done = cyc;
            done_cnt = done_cnt + 1;
         end
      end
      p_sc = ser_clk;
      p_sd = ser_data;
      p_de = ser_en;
      if (cyc == LIMIT) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

   task automatic idle_check(input string tag);
      @(negedge clk);
      chk(!ser_clk, tag, ser_clk, 0);
      chk(!ser_en,  tag, ser_en, 0);
      chk(!busy,    tag, busy, 0);
      chk(!done,    tag, done, 0);
   endtask

   // R1: reset state
   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      idle_check("R1");
   endtask

   task automatic run_frame(input logic [FW-1:0] f, input logic mode, input bit disturb);
      @(posedge clk);
      #1;
      bits = 0; nb = 0; done_cnt = 0; cur = '0;
      for (int k = 0; k < 16; k++) gaps[k] = -1;
      frame = f;
      am    = mode;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      @(negedge clk);
      chk(busy, "R11", busy, 1);
      if (disturb) begin
         repeat (60) @(posedge clk);
         #1;
         frame = ~f;
         am    = ~mode;
         start = 1'b1;
         @(posedge clk);
         #1 start = 1'b0;
         @(negedge clk);
         chk(busy, "R10", busy, 1);
      end
      while (done_cnt == 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(nb == NB, disturb ? "R10" : "R2", nb, NB);
      for (int k = 0; k < NB; k++)
         chk(caps[k] == f[8*k +: 8], disturb ? "R10" : "R2", caps[k], f[8*k +: 8]);
      for (int k = 1; k < NB; k++) begin
         int exp;
         exp = (k == 4) ? (mode ? GAM : GFM) : GAP;
         chk(gaps[k] == exp, (k == 4) ? (disturb ? "R9" : "R8") : "R7", gaps[k], exp);
      end
      chk(t_done - t_dfall == ENDC, "R11", t_done - t_dfall, ENDC);
      chk(done_cnt == 1, "R11", done_cnt, 1);
      chk(!busy, "R11", busy, 0);
      idle_check("R1");
      frame = '0;
      am    = 1'b0;
   endtask

   initial begin
      t_reset();
      run_frame(40'hA5_3C_0F_81_7E, 1'b0, 1'b0);   // R2 R8 FM
      run_frame(40'h12_F0_99_C3_01, 1'b1, 1'b0);   // R2 R8 AM
      run_frame(40'hFF_00_FF_00_AA, 1'b0, 1'b0);   // R2 extreme patterns
      run_frame(40'h5A_E7_18_66_B4, 1'b1, 1'b1);   // R9 R10 disturbed
      run_frame(40'h80_01_40_02_20, 1'b0, 1'b1);   // R9 R10 disturbed FM
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

endmodule